// File: doc/BRIEF.md
# Seven-Term Fixed-Point Dot-Product Accumulator

This block computes the dot product of up to seven pairs of signed fractional operands, such as the tap sum of a short FIR filter. Each operand is a 10-bit two's-complement value with nine fractional bits, so it covers [-1, 1). Operand pairs arrive one per cycle, marked by a valid strobe. A first strobe opens a new sum and a last strobe closes it.

Each 20-bit product is cut down before it is added. The six least significant bits are dropped by arithmetic truncation, and the remaining 14 bits are sign-extended to a 16-bit accumulator word. That word holds three guard bits above the 10-bit result field and three extra fractional bits below it. Three guard bits are enough for seven terms, so the running sum can never wrap, even when a partial sum leaves the output range.

Saturation is applied once, when the sum closes. The result is rounded toward negative infinity to the operand format, clamped if it is out of range, and presented together with an overflow flag for one cycle. The result and the flag then hold until the next sum completes.

Top module: `gmac_dot7`

## Requirements
- R1: While rst_n is low, res_valid, res_data and res_ovf are all 0, and the accumulator and term counter are cleared.
- R2: Each term contributes floor(a*b / 64) in units of 2^-12, where a and b are the signed integer values of in_a and in_b.
- R3: A beat with in_valid=1 and in_first=1 discards whatever sum was in progress and starts a new sum with that beat's term.
- R4: Every beat with in_valid=1 and in_first=0 adds its term to the running sum. At most seven terms are summed between two first beats.
- R5: res_valid is 1 for exactly the one cycle that follows a beat with in_valid=1 and in_last=1, and it is 0 at all other times.
- R6: When the final sum S (in units of 2^-12) satisfies -4096 <= S <= 4095, res_data equals floor(S/8) as a 10-bit signed value and res_ovf is 0.
- R7: When the final sum exceeds the positive range, res_data is +511 (10'h1FF) and res_ovf is 1.
- R8: When the final sum is below the negative range, res_data is -512 (10'h200) and res_ovf is 1.
- R9: A partial sum that leaves the output range does not corrupt the result, provided the final sum is back in range.
- R10: The product -512 x -512 (+1.0) is not wrapped. As a single-term sum it produces +511 with res_ovf set.
- R11: res_data and res_ovf change only in the cycle in which res_valid is 1, and they hold until the next result.
- R12: Cycles with in_valid=0 leave the running sum unchanged, whatever values are on in_a, in_b, in_first and in_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair present this cycle |
| in_first | input | 1 | This term opens a new sum |
| in_last | input | 1 | This term closes the sum |
| in_a | input | 10 | First operand, signed, nine fractional bits |
| in_b | input | 10 | Second operand, signed, nine fractional bits |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 10 | Saturated result, signed, nine fractional bits |
| res_ovf | output | 1 | Set when the result was clamped, held with the result |

## Verification
A result is due in the cycle right after the clock edge that captures the last beat. The bench drives each beat on a falling edge. On the falling edge after the last beat it checks that res_valid is high and compares res_data and res_ovf with a bench model. One falling edge later it checks that res_valid has dropped and that the result and flag are unchanged. Directed sequences place idle gaps between beats, restart a sum partway through, and cover the corner cases of the -512 x -512 product and of a partial sum that leaves the output range.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
  localparam int DEF_DATA_W    = 10;
  localparam int DEF_N_TERMS   = 7;
  localparam int DEF_KEEP_FRAC = 3;
endpackage

// File: rtl/gmac_trim.sv
module gmac_trim #(
  parameter int DATA_W = 10,
  parameter int DROP   = 6,
  localparam int PROD_W = 2 * DATA_W,
  localparam int TRIM_W = PROD_W - DROP
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [TRIM_W-1:0] term
);
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = $signed(a) * $signed(b);
    term = prod[PROD_W-1:DROP];
  end
endmodule

// File: rtl/gmac_accum.sv
module gmac_accum #(
  parameter int TRIM_W  = 14,
  parameter int ACC_W   = 16,
  parameter int N_TERMS = 7,
  localparam int CNT_W  = $clog2(N_TERMS + 1),
  localparam int EXT_W  = ACC_W - TRIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [TRIM_W-1:0] term,
  output logic [ACC_W-1:0]  sum_next
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] term_ext;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    term_ext = {{EXT_W{term[TRIM_W-1]}}, term};
    sum_next = (restart ? '0 : acc_q) + term_ext;
    cnt_d    = restart ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (step_en) begin
      acc_q <= sum_next;
      cnt_q <= cnt_d;
    end
  end

  // R12: idle cycles leave the running sum untouched
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(acc_q));

  // R4: a continuing beat never pushes past the guarded term count
  a_r4_term_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !restart) |-> (cnt_q < CNT_W'(N_TERMS)));
endmodule

// File: rtl/gmac_sat.sv
module gmac_sat #(
  parameter int ACC_W     = 16,
  parameter int DATA_W    = 10,
  parameter int KEEP_FRAC = 3,
  localparam int TOP_LSB  = KEEP_FRAC + DATA_W - 1
) (
  input  logic [ACC_W-1:0]  sum,
  output logic [DATA_W-1:0] value,
  output logic              ovf
);
  logic [ACC_W-1:TOP_LSB] top_bits;

  always_comb begin
    top_bits = sum[ACC_W-1:TOP_LSB];
    ovf      = !((&top_bits) || !(|top_bits));
    if (!ovf)
      value = sum[TOP_LSB:KEEP_FRAC];
    else if (sum[ACC_W-1])
      value = {1'b1, {(DATA_W-1){1'b0}}};
    else
      value = {1'b0, {(DATA_W-1){1'b1}}};
  end
endmodule

// File: rtl/gmac_dot7.sv
module gmac_dot7 #(
  parameter int DATA_W    = gmac_pkg::DEF_DATA_W,
  parameter int N_TERMS   = gmac_pkg::DEF_N_TERMS,
  parameter int KEEP_FRAC = gmac_pkg::DEF_KEEP_FRAC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ovf
);
  localparam int GUARD  = $clog2(N_TERMS);
  localparam int PROD_W = 2 * DATA_W;
  localparam int DROP   = DATA_W - 1 - KEEP_FRAC;
  localparam int TRIM_W = PROD_W - DROP;
  localparam int ACC_W  = DATA_W + GUARD + KEEP_FRAC;

  logic [TRIM_W-1:0] term;
  logic [ACC_W-1:0]  sum_next;
  logic [DATA_W-1:0] sat_value;
  logic              sat_ovf;
  logic              close_en;

  logic              vld_d;
  logic [DATA_W-1:0] data_d;
  logic              ovf_d;

  gmac_trim #(.DATA_W(DATA_W), .DROP(DROP)) u_trim (
    .a(in_a), .b(in_b), .term(term)
  );

  gmac_accum #(.TRIM_W(TRIM_W), .ACC_W(ACC_W), .N_TERMS(N_TERMS)) u_accum (
    .clk(clk), .rst_n(rst_n), .step_en(in_valid), .restart(in_first),
    .term(term), .sum_next(sum_next)
  );

  gmac_sat #(.ACC_W(ACC_W), .DATA_W(DATA_W), .KEEP_FRAC(KEEP_FRAC)) u_sat (
    .sum(sum_next), .value(sat_value), .ovf(sat_ovf)
  );

  always_comb begin
    close_en = in_valid && in_last;
    vld_d    = close_en;
    data_d   = close_en ? sat_value : res_data;
    ovf_d    = close_en ? sat_ovf   : res_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= vld_d;
      res_data  <= data_d;
      res_ovf   <= ovf_d;
    end
  end

  // R5: strobe follows a closing beat and nothing else
  a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> res_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> !res_valid);

  // R11: result and flag hold between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_data) && $stable(res_ovf)));

  // R7, R8: a flagged result sits on one of the two rails
  a_r7_r8_rails: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf |-> ((res_data == {1'b0, {(DATA_W-1){1'b1}}}) ||
                 (res_data == {1'b1, {(DATA_W-1){1'b0}}})));

  // R2: the trimmed term keeps the true sign of the product
  a_r2_term_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a != '0) && (in_b != '0)) |->
      (term[TRIM_W-1] == (in_a[DATA_W-1] ^ in_b[DATA_W-1])));
endmodule

// File: tb/sim_gmac_dot7.sv
module sim_gmac_dot7;
  localparam int CLK_P = 10;
  localparam int NV    = 6;

  // operand table and expected overflow flag per row
  localparam int VA [NV][7] = '{
    '{100, 100, 100, 100, 100, 100, 100},
    '{-512, -512, -512, -512, -512, -512, -512},
    '{-512, -512, -512, -512, -512, -512, -512},
    '{511, 511, 511, -511, -511, -511, 10},
    '{-3, -3, -3, -3, -3, -3, -3},
    '{300, -200, 150, -450, 511, -1, 77}
  };
  localparam int VB [NV][7] = '{
    '{50, 50, 50, 50, 50, 50, 50},
    '{-512, -512, -512, -512, -512, -512, -512},
    '{511, 511, 511, 511, 511, 511, 511},
    '{511, 511, 511, 511, 511, 511, 10},
    '{5, 5, 5, 5, 5, 5, 5},
    '{-400, 250, -100, 333, 200, 9, -77}
  };
  localparam bit VOVF [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first, in_last;
  logic [9:0] in_a, in_b;
  logic       res_valid;
  logic [9:0] res_data;
  logic       res_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  gmac_dot7 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_a(in_a), .in_b(in_b), .res_valid(res_valid),
    .res_data(res_data), .res_ovf(res_ovf)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int term_of(input int a, input int b);
    return (a * b) >>> 6;
  endfunction

  function automatic int out_of(input int s);
    int q;
    q = s >>> 3;
    if (q > 511) q = 511;
    if (q < -512) q = -512;
    return q;
  endfunction

  function automatic bit ovf_of(input int s);
    return ((s >>> 3) > 511) || ((s >>> 3) < -512);
  endfunction

  task automatic beat(input int a, input int b, input bit f, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_last = l;
    in_a = 10'(a); in_b = 10'(b);
  endtask

  task automatic idle(input int a, input int b);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1;
    in_a = 10'(a); in_b = 10'(b);
  endtask

  // checks the strobe edge after the closing beat and the cycle after it
  task automatic expect_result(input int s, input string req);
    int exp_d;
    bit exp_o;
    exp_d = out_of(s);
    exp_o = ovf_of(s);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    check(res_valid == 1'b1, {req, " R5 strobe"}, int'(res_valid), 1);
    check($signed(res_data) == exp_d, {req, " data"}, $signed(res_data), exp_d);
    check(res_ovf == exp_o, {req, " ovf"}, int'(res_ovf), int'(exp_o));
    @(negedge clk);
    check(res_valid == 1'b0, "R5 one cycle", int'(res_valid), 0);
    check($signed(res_data) == exp_d, "R11 data held", $signed(res_data), exp_d);
    check(res_ovf == exp_o, "R11 ovf held", int'(res_ovf), int'(exp_o));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;
    rst_n = 1'b0;
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    check(res_data == '0, "R1 data", int'(res_data), 0);
    check(res_ovf == 1'b0, "R1 ovf", int'(res_ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R4 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      s = 0;
      for (int k = 0; k < 7; k++) begin
        s += term_of(VA[v][k], VB[v][k]);
        beat(VA[v][k], VB[v][k], k == 0, k == 6);
      end
      check(ovf_of(s) == VOVF[v], "R6 table model", int'(ovf_of(s)), int'(VOVF[v]));
      expect_result(s, "R4 R6 R7 R8 R9 table");
    end

    // R10: single term -512 x -512 clamps to +511
    beat(-512, -512, 1'b1, 1'b1);
    expect_result(4096, "R10 single");
    check($signed(res_data) == 511, "R10 rail", $signed(res_data), 511);

    // R8: negative rail
    s = 0;
    for (int k = 0; k < 7; k++) begin
      s += term_of(511, -512);
      beat(511, -512, k == 0, k == 6);
    end
    expect_result(s, "R8 rail");
    check($signed(res_data) == -512, "R8 rail value", $signed(res_data), -512);

    // R12: idle gaps with noisy inputs do not disturb the sum
    s = term_of(200, 100) + term_of(-150, 60) + term_of(7, -9);
    beat(200, 100, 1'b1, 1'b0);
    idle(-512, -512);
    idle(511, 511);
    beat(-150, 60, 1'b0, 1'b0);
    idle(-300, 3);
    beat(7, -9, 1'b0, 1'b1);
    expect_result(s, "R12 gaps");

    // R3: restart partway discards the earlier partial sum
    beat(400, 400, 1'b1, 1'b0);
    beat(400, 400, 1'b0, 1'b0);
    s = term_of(-20, 30) + term_of(15, 15);
    beat(-20, 30, 1'b1, 1'b0);
    beat(15, 15, 1'b0, 1'b1);
    expect_result(s, "R3 restart");

    // R11: result held across a partial sum without a close
    beat(100, 100, 1'b1, 1'b0);
    beat(100, 100, 1'b0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    check($signed(res_data) == out_of(s), "R11 held mid-sum", $signed(res_data), out_of(s));
    check(res_valid == 1'b0, "R5 no close no strobe", int'(res_valid), 0);

    // R1: asynchronous reset mid-operation clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(res_data == '0, "R1 re-reset data", int'(res_data), 0);
    rst_n = 1'b1;
    // R1: accumulator cleared, so a continuing beat adds to zero
    beat(64, 64, 1'b0, 1'b1);
    expect_result(term_of(64, 64), "R1 acc cleared");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule